// File: doc/BRIEF.md
# Random Number Source Register Front End

This block places a hardware random number source behind a small 32-bit register interface. Software sees three words: a control word, a status word and a data word. Setting the run bit starts sample production into a four-word output buffer, and data reads drain that buffer oldest first. The status word reports whether samples are waiting, and it reports clock and seed faults through two kinds of flag. A live flag follows the fault. A sticky flag keeps a record of it until software clears it.

The generation settings (clock-error detection off, divider exponent and the other bits 29:4) form a protected set. It changes only when the new value comes in the same write that raises the subsystem-reset bit (bit 30). That bit stays high while software holds it, and for a fixed number of cycles after software releases it. During that time the buffer is emptied and the live seed fault is cleared. The entropy stand-in is a 32-bit Galois LFSR. An injection input simulates a seed fault, which stops generation and makes data reads return zero. One build variant recovers from a seed fault by itself.

Top module: `rng_top`

## Requirements
- R1: The control word sits at offset 0x0, the status word at 0x4 and the data word at 0x8. A read of any other offset returns zero.
- R2: Control bit 2 (run) and bit 3 (interrupt enable) take every control write. The control readback is {0, resetBusy, cfg[29:4], ie, run, 2'b00}, and it is zero after reset.
- R3: Control bits 29:4 are stored only by a control write that also has bit 30 set. In that setting, bit 5 turns off clock-error detection and bits 19:16 hold the divider exponent. A control write without bit 30 leaves these bits unchanged.
- R4: Bit 30 reads 1 from the write that sets it until a control write clears it, and then for RST_CYCLES more cycles. While it reads 1, the buffer is emptied, the live seed flag is cleared and seed injection is ignored.
- R5: With run set and no reset or seed fault present, one word is pushed every 2^exponent cycles while the buffer holds fewer than 4 words. The words follow the LFSR sequence (Galois right shift with mask 0x80200003, starting from SEED), so they are never zero.
- R6: Status bit 0 (ready) is 1 when the buffer is not empty and there is no live seed fault. A data read then returns the oldest word and removes it.
- R7: Seed injection sets the live seed flag (status bit 2) and the sticky seed flag (status bit 6) on the next cycle, and stops generation. While the live flag is set, data reads return zero and remove nothing.
- R8: With AUTO_RECOVER=0, the live seed flag stays set until a subsystem reset clears it.
- R9: With AUTO_RECOVER=1, the live seed flag clears by itself RST_CYCLES cycles after the last injection cycle, and the buffer is emptied. The sticky flag stays set.
- R10: When detection is enabled, a clock-error input sets the live clock flag (status bit 1, one cycle later, following the input) and the sticky clock flag (status bit 5). When detection is off, the input has no effect.
- R11: Writing 0 to status bit 5 or bit 6 clears that sticky flag. Writing 1 leaves it as it is, and a new fault in the same cycle keeps it set.
- R12: irq equals ie AND (ready OR sticky clock flag OR sticky seed flag).
- R13: A data read of an empty buffer returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a data read removes a word) |
| addr | input | ADDR_W | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addr |
| seedErrInj | input | 1 | Seed fault injection |
| clkErrInj | input | 1 | Clock fault input |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the buffer never holds more than four words and that it does not grow while a seed fault is live. They also check that a reset period empties the buffer and clears the live seed flag, that injection outside a reset always raises the live flag, and that data reads return zero during a fault. Only the bench scenarios can show the rest. These are the protected configuration being ignored or latched, the exact length of the reset period, the two recovery variants side by side, the clearing rules of the sticky flags, and the order of the sample sequence. A behavioural queue model compares every readback and the interrupt on each cycle.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_DATA = 8;

  localparam int unsigned EN_BIT     = 2;
  localparam int unsigned IE_BIT     = 3;
  localparam int unsigned CFG_LSB    = 4;
  localparam int unsigned CFG_MSB    = 29;
  localparam int unsigned CRST_BIT   = 30;
  localparam int unsigned CEDOFF_BIT = 5;
  localparam int unsigned DIV_LSB    = 16;
  localparam int unsigned DIV_W      = 4;
  localparam int unsigned CFG_W      = CFG_MSB - CFG_LSB + 1;

  localparam int unsigned ST_CLK_STICKY  = 5;
  localparam int unsigned ST_SEED_STICKY = 6;

  typedef enum logic [1:0] {CR_IDLE, CR_HELD, CR_DRAIN} crState_t;

  typedef struct packed {
    logic             runEn;
    logic             flush;
    logic             pop;
    logic [DIV_W-1:0] divExp;
  } dpStrobe_t;
endpackage

// File: rtl/rng_datapath.sv
module rng_datapath import rng_pkg::*; #(
  parameter int unsigned DEPTH = 4,
  parameter logic [31:0] SEED  = 32'hACE1_2468,
  parameter logic [31:0] TAPS  = 32'h8020_0003,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned PRE_W = 1 << DIV_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic [31:0]      head,
  output logic [CNT_W-1:0] count
);
  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [31:0]      lfsr;
  logic [PRE_W-1:0] pre, preLimit;
  logic             tick, push, popOk;

  assign preLimit = (PRE_W'(1) << strobe.divExp) - PRE_W'(1);
  assign tick     = strobe.runEn && (pre == preLimit);
  assign push     = tick && (count < CNT_W'(DEPTH)) && !strobe.flush;
  assign popOk    = strobe.pop && (count != '0) && !strobe.flush;
  assign head     = mem[rdPtr];

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pre <= '0;
    else if (!strobe.runEn || tick) pre <= '0;
    else pre <= pre + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr  <= SEED;
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        wrPtr <= ptrInc(wrPtr);
        lfsr  <= (lfsr >> 1) ^ (lfsr[0] ? TAPS : 32'h0);
      end
      if (popOk) rdPtr <= ptrInc(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(popOk);
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && wrPtr == PTR_W'(i)) mem[i] <= lfsr;
      end
    end
  endgenerate
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl import rng_pkg::*; #(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned DEPTH        = 4,
  parameter int unsigned RST_CYCLES   = 8,
  parameter bit          AUTO_RECOVER = 1'b0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned RC_W  = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              seedErrInj,
  input  logic              clkErrInj,
  output logic              irq,
  input  logic [31:0]       head,
  input  logic [CNT_W-1:0]  count,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              liveSeed
);
  crState_t         crState;
  logic [RC_W-1:0]  rcCnt;
  logic [CFG_W-1:0] cfg;
  logic             enBit, ieBit;
  logic             liveClk, stickyClk, stickySeed;
  logic             ctrlWr, statWr, dataSel, ctrlSel, statSel;
  logic             cedOff, drdy, seedHit, clkHit, autoDone;
  logic             unusedWr;

  assign ctrlSel  = addr == ADDR_W'(OFS_CTRL);
  assign statSel  = addr == ADDR_W'(OFS_STAT);
  assign dataSel  = addr == ADDR_W'(OFS_DATA);
  assign ctrlWr   = wrEn && ctrlSel;
  assign statWr   = wrEn && statSel;
  assign unusedWr = ^{wrData[31], wrData[1:0]};

  assign busy    = crState != CR_IDLE;
  assign cedOff  = cfg[CEDOFF_BIT - CFG_LSB];
  assign seedHit = seedErrInj && !busy;
  assign clkHit  = clkErrInj && !cedOff;
  assign drdy    = (count != '0) && !liveSeed;

  assign strobe.runEn  = enBit && !busy && !liveSeed;
  assign strobe.flush  = busy || autoDone;
  assign strobe.pop    = rdEn && dataSel && drdy;
  assign strobe.divExp = cfg[DIV_LSB - CFG_LSB +: DIV_W];

  assign irq = ieBit && (drdy || stickyClk || stickySeed);

  always_comb begin
    rdData = 32'h0;
    if (ctrlSel)
      rdData = {1'b0, busy, cfg, ieBit, enBit, 2'b00};
    else if (statSel)
      rdData = {25'h0, stickySeed, stickyClk, 2'b00, liveSeed, liveClk, drdy};
    else if (dataSel)
      rdData = drdy ? head : 32'h0;
  end

  // subsystem reset sequencer and protected configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crState <= CR_IDLE;
      rcCnt   <= '0;
      cfg     <= '0;
      enBit   <= 1'b0;
      ieBit   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enBit <= wrData[EN_BIT];
        ieBit <= wrData[IE_BIT];
      end
      if (ctrlWr && wrData[CRST_BIT]) begin
        crState <= CR_HELD;
        cfg     <= wrData[CFG_MSB:CFG_LSB];
      end else if (ctrlWr && crState == CR_HELD) begin
        crState <= CR_DRAIN;
        rcCnt   <= RC_W'(RST_CYCLES);
      end else if (crState == CR_DRAIN) begin
        if (rcCnt <= RC_W'(1)) crState <= CR_IDLE;
        else rcCnt <= rcCnt - RC_W'(1);
      end
    end
  end

  // fault flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveClk    <= 1'b0;
      stickyClk  <= 1'b0;
      liveSeed   <= 1'b0;
      stickySeed <= 1'b0;
    end else begin
      liveClk <= clkHit;
      if (clkHit) stickyClk <= 1'b1;
      else if (statWr && !wrData[ST_CLK_STICKY]) stickyClk <= 1'b0;

      if (seedHit) stickySeed <= 1'b1;
      else if (statWr && !wrData[ST_SEED_STICKY]) stickySeed <= 1'b0;

      if (busy) liveSeed <= 1'b0;
      else if (seedErrInj) liveSeed <= 1'b1;
      else if (autoDone) liveSeed <= 1'b0;
    end
  end

  generate
    if (AUTO_RECOVER) begin : g_auto
      logic [RC_W-1:0] recCnt;
      assign autoDone = liveSeed && !seedHit && !busy && (recCnt == RC_W'(1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) recCnt <= '0;
        else if (seedHit) recCnt <= RC_W'(RST_CYCLES);
        else if (liveSeed && recCnt != '0) recCnt <= recCnt - RC_W'(1);
      end
    end else begin : g_manual
      assign autoDone = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rng_top.sv
module rng_top import rng_pkg::*; #(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned DEPTH        = 4,
  parameter int unsigned RST_CYCLES   = 8,
  parameter bit          AUTO_RECOVER = 1'b0,
  parameter logic [31:0] SEED         = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              seedErrInj,
  input  logic              clkErrInj,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  dpStrobe_t        strobe;
  logic [31:0]      head;
  logic [CNT_W-1:0] fifoCount;
  logic             busy, liveSeed;

  rng_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES),
             .AUTO_RECOVER(AUTO_RECOVER)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .seedErrInj(seedErrInj),
    .clkErrInj(clkErrInj), .irq(irq), .head(head), .count(fifoCount),
    .strobe(strobe), .busy(busy), .liveSeed(liveSeed)
  );

  rng_datapath #(.DEPTH(DEPTH), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .head(head), .count(fifoCount)
  );
endmodule

// File: rtl/rng_checks.sv
module rng_checks #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdData,
  input logic              seedErrInj,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              busy,
  input logic              liveSeed
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH)); // R5
  AST_NO_GROWTH_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    liveSeed |=> fifoCount <= $past(fifoCount)); // R7
  AST_INJ_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (seedErrInj && !busy) |=> liveSeed); // R7
  AST_ZERO_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (liveSeed && addr == ADDR_W'(8)) |-> rdData == 32'h0); // R7
  AST_RESET_FLUSHES: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> fifoCount == '0); // R4
  AST_RESET_CLEARS_SEED: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !liveSeed); // R4
endmodule

bind rng_top rng_checks #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_checks (
  .clk(clk), .rstN(rstN), .addr(addr), .rdData(rdData),
  .seedErrInj(seedErrInj), .fifoCount(fifoCount), .busy(busy),
  .liveSeed(liveSeed)
);

// File: tb/sim_rng_top.sv
`timescale 1ns/100ps
module sim_rng_top;
  localparam int RSTC = 8;
  localparam logic [31:0] SEED = 32'hACE1_2468;

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, seedErrInj = 0, clkErrInj = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rd0, rd1;
  logic irq0, irq1;
  int nChk = 0, nFail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rng_top #(.RST_CYCLES(RSTC), .AUTO_RECOVER(1'b0), .SEED(SEED)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rd0), .seedErrInj(seedErrInj), .clkErrInj(clkErrInj), .irq(irq0));
  rng_top #(.RST_CYCLES(RSTC), .AUTO_RECOVER(1'b1), .SEED(SEED)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rd1), .seedErrInj(seedErrInj), .clkErrInj(clkErrInj), .irq(irq1));

  // behavioural reference model, index 0 = manual recovery, 1 = auto recovery
  bit        mEn[2], mIe[2], mLiveClk[2], mStClk[2], mLiveSeed[2], mStSeed[2];
  int        mCr[2], mRc[2], mRec[2], mPre[2];
  bit [25:0] mCfg[2];
  bit [31:0] mLfsr[2];
  bit [31:0] q0[$], q1[$];

  function automatic bit [31:0] lfsrNext(bit [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic int qSize(int m);
    return (m == 0) ? q0.size() : q1.size();
  endfunction

  function automatic bit [31:0] qHead(int m);
    return (m == 0) ? q0[0] : q1[0];
  endfunction

  function automatic bit [31:0] modelRead(int m, logic [3:0] a);
    bit rdy;
    rdy = (qSize(m) != 0) && !mLiveSeed[m];
    case (a)
      4'h0: return {1'b0, mCr[m] != 0, mCfg[m], mIe[m], mEn[m], 2'b00};
      4'h4: return {25'h0, mStSeed[m], mStClk[m], 2'b00, mLiveSeed[m], mLiveClk[m], rdy};
      4'h8: return rdy ? qHead(m) : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelStep(int m);
    bit busy, autoDone, flush, pop, push, runEn, tick, seedHit, clkHit, ctrlWr, statWr;
    int div;
    busy = mCr[m] != 0;
    seedHit = seedErrInj && !busy;
    autoDone = (m == 1) && mLiveSeed[m] && !seedHit && !busy && mRec[m] == 1;
    flush = busy || autoDone;
    pop = rdEn && addr == 4'h8 && qSize(m) != 0 && !mLiveSeed[m] && !flush;
    runEn = mEn[m] && !busy && !mLiveSeed[m];
    div = int'(mCfg[m][15:12]);
    tick = runEn && mPre[m] == (1 << div) - 1;
    push = tick && qSize(m) < 4 && !flush;
    ctrlWr = wrEn && addr == 4'h0;
    statWr = wrEn && addr == 4'h4;
    clkHit = clkErrInj && !mCfg[m][1];
    mPre[m] = (!runEn || tick) ? 0 : mPre[m] + 1;
    if (flush) begin
      if (m == 0) q0.delete(); else q1.delete();
    end else begin
      if (pop) begin if (m == 0) void'(q0.pop_front()); else void'(q1.pop_front()); end
      if (push) begin
        if (m == 0) q0.push_back(mLfsr[m]); else q1.push_back(mLfsr[m]);
        mLfsr[m] = lfsrNext(mLfsr[m]);
      end
    end
    if (m == 1) begin
      if (seedHit) mRec[m] = RSTC;
      else if (mLiveSeed[m] && mRec[m] != 0) mRec[m]--;
    end
    mLiveClk[m] = clkHit;
    if (clkHit) mStClk[m] = 1; else if (statWr && !wrData[5]) mStClk[m] = 0;
    if (seedHit) mStSeed[m] = 1; else if (statWr && !wrData[6]) mStSeed[m] = 0;
    if (busy) mLiveSeed[m] = 0;
    else if (seedErrInj) mLiveSeed[m] = 1;
    else if (autoDone) mLiveSeed[m] = 0;
    if (ctrlWr) begin mEn[m] = wrData[2]; mIe[m] = wrData[3]; end
    if (ctrlWr && wrData[30]) begin mCr[m] = 1; mCfg[m] = wrData[29:4]; end
    else if (ctrlWr && mCr[m] == 1) begin mCr[m] = 2; mRc[m] = RSTC; end
    else if (mCr[m] == 2) begin
      if (mRc[m] <= 1) mCr[m] = 0; else mRc[m]--;
    end
  endtask

  task automatic modelReset();
    for (int m = 0; m < 2; m++) begin
      mEn[m] = 0; mIe[m] = 0; mLiveClk[m] = 0; mStClk[m] = 0; mLiveSeed[m] = 0;
      mStSeed[m] = 0; mCr[m] = 0; mRc[m] = 0; mRec[m] = 0; mPre[m] = 0;
      mCfg[m] = 0; mLfsr[m] = SEED;
    end
    q0.delete(); q1.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) modelReset();
    else for (int m = 0; m < 2; m++) modelStep(m);
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && cyc > 1) begin
      string tag;
      tag = (addr == 4'h0) ? "R2" : (addr == 4'h4) ? "R6" : (addr == 4'h8) ? "R5" : "R1";
      check(tag, rd0, modelRead(0, addr));
      check(tag, rd1, modelRead(1, addr));
      check("R12", {31'h0, irq0}, {31'h0, mIe[0] && ((qSize(0) != 0 && !mLiveSeed[0]) || mStClk[0] || mStSeed[0])});
      check("R12", {31'h0, irq1}, {31'h0, mIe[1] && ((qSize(1) != 0 && !mLiveSeed[1]) || mStClk[1] || mStSeed[1])});
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      nFail++; nChk++;
      $display("FAIL watchdog: got %0d expected below 100000 cycles", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); #0.5; wrEn = 1; addr = a; wrData = d;
    @(negedge clk); #0.5; wrEn = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] g0, output logic [31:0] g1);
    @(negedge clk); #0.5; rdEn = 1; addr = a; #0.5; g0 = rd0; g1 = rd1;
    @(negedge clk); #0.5; rdEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit seed);
    @(negedge clk); #0.5; if (seed) seedErrInj = 1; else clkErrInj = 1;
    @(negedge clk); #0.5; seedErrInj = 0; clkErrInj = 0;
  endtask

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    #0.5 rstN = 1;
    rd(4'h0, a, b); check("R2 reset ctrl", a, 32'h0);
    rd(4'h4, a, b); check("R6 reset status", a, 32'h0);
    rd(4'h8, a, b); check("R13 empty read", a, 32'h0);
    // run with exponent 0 through a subsystem reset
    wr(4'h0, 32'h4000_0004);
    rd(4'h0, a, b); check("R4 held bit30", a & 32'h4000_0000, 32'h4000_0000);
    wr(4'h0, 32'h0000_0004);
    idle(RSTC + 8);
    rd(4'h4, a, b); check("R6 ready", a & 32'h1, 32'h1);
    rd(4'h8, a, b); check("R5 first word", a, SEED);
    rd(4'h8, a, b); check("R5 second word", a, lfsrNext(SEED));
    // protected config ignored without bit 30
    wr(4'h0, 32'h000F_0024);
    rd(4'h0, a, b); check("R3 ignored", a, 32'h0000_0004);
    wr(4'h0, 32'h4003_0004);
    wr(4'h0, 32'h0000_0004);
    rd(4'h0, a, b); check("R4 draining", a, 32'h4003_0004);
    idle(RSTC);
    rd(4'h0, a, b); check("R3 latched", a, 32'h0003_0004);
    idle(40);
    for (int i = 0; i < 5; i++) rd(4'h8, a, b);
    // clock error with detection on
    pulse(0);
    rd(4'h4, a, b); check("R10 sticky clk", a & 32'h22, 32'h20);
    wr(4'h4, 32'h0000_0020);
    rd(4'h4, a, b); check("R11 write one keeps", a & 32'h20, 32'h20);
    wr(4'h4, 32'h0);
    rd(4'h4, a, b); check("R11 cleared", a & 32'h20, 32'h0);
    // detection off
    wr(4'h0, 32'h4003_0024); wr(4'h0, 32'h0000_0004); idle(RSTC);
    pulse(0);
    rd(4'h4, a, b); check("R10 disabled", a & 32'h22, 32'h0);
    idle(40);
    // seed fault
    pulse(1);
    rd(4'h4, a, b); check("R7 flags", a & 32'h45, 32'h44);
    rd(4'h8, a, b); check("R7 zero data", a, 32'h0);
    wr(4'h0, 32'h0000_000C);
    idle(RSTC + 4);
    rd(4'h4, a, b);
    check("R8 manual stays", a & 32'h44, 32'h44);
    check("R9 auto recovered", b & 32'h44, 32'h40);
    check("R12 irq on sticky", {31'h0, irq0}, 32'h1);
    wr(4'h4, 32'h0000_0040);
    rd(4'h4, a, b); check("R11 seed keeps", a & 32'h40, 32'h40);
    wr(4'h0, 32'h4003_002C); wr(4'h0, 32'h0000_000C); idle(RSTC + 2);
    rd(4'h4, a, b); check("R8 cleared by reset", a & 32'h44, 32'h40);
    wr(4'h4, 32'h0);
    idle(40);
    rd(4'h8, a, b); check("R6 data after recovery", {31'h0, a != 0}, 32'h1);
    // offsets and empty buffer
    rd(4'hC, a, b); check("R1 unmapped", a, 32'h0);
    wr(4'h0, 32'h4003_0020); wr(4'h0, 32'h0); idle(RSTC + 2);
    rd(4'h8, a, b); check("R13 empty after flush", a, 32'h0);
    idle(4);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule